// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous up-counter, four bits wide by default, with an active-low parallel load, two count enables and a combinational terminal-count flag. All flops update together on the rising clock edge. A parameter fixes the clear style when the block is built. One choice is an immediate, level-sensitive clear. The other is a clear that takes effect only at the next clock edge.

Wider counters are made by chaining stages on one shared clock. Each stage's terminal-count flag drives the trickle enable of the next stage. Because only the trickle enable gates the flag, an enable at the bottom of the chain ripples combinationally through every stage in the same cycle.

With the synchronous clear, a shorter count cycle needs only a decode of the last wanted value fed back to the clear. No load path is involved.

Top module: `casc_counter`

## Requirements
- R1: With ASYNC_CLR=1, a low level on clr_ni drives count_o to 0 at once, without a clock edge, whatever the levels on load_ni, en_par_i, en_trk_i and data_i.
- R2: With ASYNC_CLR=0, a low clr_ni leaves count_o unchanged until the next rising edge. At that edge count_o becomes 0, overriding load and both enables.
- R3: With clear inactive, load_ni low at a rising edge copies data_i into count_o, whatever the enable levels.
- R4: With clear inactive, load_ni high and both en_par_i and en_trk_i high, each rising edge adds one to count_o.
- R5: With clear inactive and load_ni high, if either enable is low the count holds across the edge.
- R6: The count runs in binary and wraps from all ones (15) to 0 on an enabled edge.
- R7: tc_o is high exactly when en_trk_i is high and count_o is all ones. It follows en_trk_i combinationally, with no clock edge needed.
- R8: With ASYNC_CLR=1, tc_o falls together with the immediate clear.
- R9: Three stages chained through tc_o to en_trk_i on one clock form a 12-bit counter that steps by one per enabled edge, holds when disabled and wraps from 4095 to 0.
- R10: With ASYNC_CLR=0, feeding a decode of count 6 back to clr_ni makes the counter cycle 0 through 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| clr_ni | input | 1 | Clear, active low; immediate or edge-timed according to ASYNC_CLR |
| load_ni | input | 1 | Parallel load, active low |
| en_par_i | input | 1 | Count enable that does not reach tc_o |
| en_trk_i | input | 1 | Count enable that also gates tc_o |
| data_i | input | WIDTH | Value to load |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal-count flag |

## Verification
The functions that collide most often are the clear and the load. In the synchronous build the bench drives clr_ni and load_ni low on the same edge, with the enables high, and expects zero, not the data. In the immediate build it lowers the clear between edges while the load is requested and the synchronous copy is still waiting. The bench then requires the immediate copy to read zero before the edge, and the other copy to keep its old value until that edge. A second collision is the wrap into all ones and the trickle enable moving within the same cycle. Here tc_o is sampled mid-cycle, before and after en_trk_i toggles.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      clr_ni,
  input  logic      load_ni,
  input  logic      en_par_i,
  input  logic      en_trk_i,
  output cnt_mode_e mode_o
);
  // fixed priority: clear, load, count, hold
  always_comb begin
    if (!clr_ni)                  mode_o = MODE_CLEAR;
    else if (!load_ni)            mode_o = MODE_LOAD;
    else if (en_par_i && en_trk_i) mode_o = MODE_COUNT;
    else                          mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_mode_e        mode_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] inc;

  // lookahead incrementer: bit toggles when all lower bits are set
  assign inc[0] = ~cur_i[0];
  for (genvar i = 1; i < WIDTH; i++) begin : g_inc
    assign inc[i] = cur_i[i] ^ (&cur_i[i-1:0]);
  end

  always_comb begin
    unique case (mode_i)
      MODE_CLEAR: nxt_o = '0;
      MODE_LOAD:  nxt_o = data_i;
      MODE_COUNT: nxt_o = inc;
      default:    nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (ASYNC_CLR) begin : g_async
    always_ff @(posedge clk_i or negedge clr_ni) begin
      if (!clr_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_sync
    // clear arrives through d_i from the mode decode
    always_ff @(posedge clk_i) q_o <= d_i;
  end
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             en_par_i,
  input  logic             en_trk_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam logic [WIDTH-1:0] TERM = '1;

  cnt_mode_e        mode;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  cnt_mode_dec u_dec (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .en_par_i(en_par_i),
    .en_trk_i(en_trk_i),
    .mode_o  (mode)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .mode_i(mode),
    .cur_i (cnt_q),
    .data_i(data_i),
    .nxt_o (cnt_d)
  );

  cnt_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk_i (clk_i),
    .clr_ni(clr_ni),
    .d_i   (cnt_d),
    .q_o   (cnt_q)
  );

  assign count_o = cnt_q;
  // only the trickle enable gates the flag, so chains settle in one cycle
  assign tc_o    = en_trk_i & (cnt_q == TERM);
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic             clk_i,
  input logic             clr_ni,
  input logic             load_ni,
  input logic             en_par_i,
  input logic             en_trk_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk_i) if (!clr_ni) armed <= 1'b1;

  // R3
  load_takes_data_chk: assert property (@(posedge clk_i) disable iff (!clr_ni || !armed)
    !load_ni |=> count_o == $past(data_i));

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!clr_ni || !armed)
    load_ni && en_par_i && en_trk_i |=> count_o == WIDTH'($past(count_o) + 1'b1));

  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!clr_ni || !armed)
    load_ni && !(en_par_i && en_trk_i) |=> $stable(count_o));

  // R6
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!clr_ni || !armed)
    load_ni && en_par_i && en_trk_i && (&count_o) |=> count_o == '0);

  // R7
  tc_needs_trickle_chk: assert property (@(posedge clk_i) disable iff (!armed)
    tc_o |-> en_trk_i && (&count_o));

  // R7
  tc_on_terminal_chk: assert property (@(posedge clk_i) disable iff (!armed)
    en_trk_i && (&count_o) |-> tc_o);

  if (ASYNC_CLR) begin : g_async_chk
    // R1
    async_clear_zero_chk: assert property (@(posedge clk_i) disable iff (!armed)
      !clr_ni |-> count_o == '0 && !tc_o);
  end else begin : g_sync_chk
    // R2
    sync_clear_edge_chk: assert property (@(posedge clk_i) disable iff (!armed)
      !clr_ni |=> count_o == '0);
  end
endmodule

bind casc_counter casc_counter_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk_i   (clk_i),
  .clr_ni  (clr_ni),
  .load_ni (load_ni),
  .en_par_i(en_par_i),
  .en_trk_i(en_trk_i),
  .data_i  (data_i),
  .count_o (count_o),
  .tc_o    (tc_o)
);

// File: tb/casc_counter_bench.sv
`timescale 1ns/1ps
module casc_counter_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       a_clr_n = 1'b0, s_clr_n = 1'b0;
  logic       ld_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] a_cnt, s_cnt, m_cnt;
  logic       a_tc, s_tc, m_tc;
  logic       m_go = 1'b0;
  logic       m_clr_n;
  logic       c_clr_n = 1'b0, c_en = 1'b0;
  logic [11:0] c_val;
  logic [2:0]  c_tc, c_trk;

  int n_cmp = 0, n_bad = 0;
  logic [3:0] exp_a, exp_s;
  bit done = 1'b0;

  casc_counter #(.ASYNC_CLR(1'b1)) u_casc_counter (
    .clk_i(clk), .clr_ni(a_clr_n), .load_ni(ld_n), .en_par_i(ep), .en_trk_i(et),
    .data_i(din), .count_o(a_cnt), .tc_o(a_tc));

  casc_counter #(.ASYNC_CLR(1'b0)) u_sync (
    .clk_i(clk), .clr_ni(s_clr_n), .load_ni(ld_n), .en_par_i(ep), .en_trk_i(et),
    .data_i(din), .count_o(s_cnt), .tc_o(s_tc));

  assign m_clr_n = m_go & (m_cnt != 4'd6);
  casc_counter #(.ASYNC_CLR(1'b0)) u_mod7 (
    .clk_i(clk), .clr_ni(m_clr_n), .load_ni(1'b1), .en_par_i(1'b1), .en_trk_i(1'b1),
    .data_i(4'd0), .count_o(m_cnt), .tc_o(m_tc));

  for (genvar g = 0; g < 3; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign c_trk[g] = c_en;
    end else begin : g_next
      assign c_trk[g] = c_tc[g-1];
    end
    casc_counter #(.ASYNC_CLR(1'b0)) u_stage (
      .clk_i(clk), .clr_ni(c_clr_n), .load_ni(1'b1), .en_par_i(c_en), .en_trk_i(c_trk[g]),
      .data_i(4'd0), .count_o(c_val[4*g +: 4]), .tc_o(c_tc[g]));
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_next(logic clr_n, logic l_n, logic p, logic t,
                                          logic [3:0] d, logic [3:0] cur);
    if (!clr_n)     return 4'd0;
    else if (!l_n)  return d;
    else if (p && t) return 4'((cur + 1) % 16);
    else            return cur;
  endfunction

  function automatic string tag(logic clr_n, logic is_async, logic [3:0] prev);
    if (!clr_n)     return is_async ? "R1 clear" : "R2 clear";
    else if (!ld_n) return "R3 load";
    else if (ep && et) return (prev == 4'd15) ? "R6 wrap" : "R4 count";
    else            return "R5 hold";
  endfunction

  // inputs were driven at the previous falling edge
  task automatic tick();
    string ta, ts;
    @(posedge clk);
    ta = tag(a_clr_n, 1'b1, exp_a);
    ts = tag(s_clr_n, 1'b0, exp_s);
    exp_a = ref_next(a_clr_n, ld_n, ep, et, din, exp_a);
    exp_s = ref_next(s_clr_n, ld_n, ep, et, din, exp_s);
    #1;
    chk(ta, 16'(a_cnt), 16'(exp_a));
    chk(ts, 16'(s_cnt), 16'(exp_s));
    chk("R7 tc async build", 16'(a_tc), 16'(et && exp_a == 4'd15));
    chk("R7 tc sync build", 16'(s_tc), 16'(et && exp_s == 4'd15));
    @(negedge clk);
  endtask

  initial begin
    logic [11:0] cexp;
    // reset state
    tick();
    a_clr_n = 1'b1; s_clr_n = 1'b1;

    // sweep of control patterns and data values
    for (int v = 0; v < 2048; v++) begin
      int c = (v * 7 + v / 16) % 16;
      a_clr_n = (c != 0);
      s_clr_n = (c != 0);
      ld_n    = !(c == 1 || c == 2);
      ep      = !(c == 3 || c == 4);
      et      = !(c == 5 || c == 6);
      din     = 4'((v * 5 + v / 3) % 16);
      if (!a_clr_n) exp_a = 4'd0;
      tick();
    end

    // clear against a pending load: immediate vs edge-timed
    a_clr_n = 1'b1; s_clr_n = 1'b1; ld_n = 1'b0; din = 4'd9; ep = 1'b1; et = 1'b1;
    tick();
    a_clr_n = 1'b0; s_clr_n = 1'b0; din = 4'd5;
    #2;
    chk("R1 cleared before edge", 16'(a_cnt), 16'd0);
    chk("R2 holds until edge", 16'(s_cnt), 16'd9);
    exp_a = 4'd0;
    tick();

    // flag follows the trickle enable without a clock edge
    a_clr_n = 1'b1; s_clr_n = 1'b1; ld_n = 1'b0; din = 4'd15; ep = 1'b0; et = 1'b0;
    tick();
    ld_n = 1'b1;
    tick();
    et = 1'b1;
    #2;
    chk("R7 tc rises with trickle", 16'(a_tc), 16'd1);
    chk("R7 tc rises with trickle", 16'(s_tc), 16'd1);
    et = 1'b0;
    #1;
    chk("R7 tc falls with trickle", 16'(a_tc), 16'd0);
    et = 1'b1;
    #1;
    a_clr_n = 1'b0;
    #1;
    chk("R8 tc drops with clear", 16'(a_tc), 16'd0);
    chk("R8 count drops with clear", 16'(a_cnt), 16'd0);
    exp_a = 4'd0;
    @(negedge clk);
    tick();

    // shortened cycle through clear feedback
    m_go = 1'b1;
    for (int k = 1; k <= 21; k++) begin
      @(posedge clk); #1;
      chk("R10 mod-7 sequence", 16'(m_cnt), 16'(k % 7));
    end
    @(negedge clk);

    // three-stage chain
    c_clr_n = 1'b1; c_en = 1'b1; cexp = 12'd0;
    for (int k = 0; k < 4100; k++) begin
      @(posedge clk); #1;
      cexp = cexp + 12'd1;
      chk("R9 chain step", 16'(c_val), 16'(cexp));
    end
    @(negedge clk);
    c_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R9 chain hold", 16'(c_val), 16'(cexp));
    end
    @(negedge clk);
    c_en = 1'b1;
    @(posedge clk); #1;
    chk("R9 chain resume", 16'(c_val), 16'(cexp + 12'd1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule